// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 128 level-sensitive interrupt lines from peripherals. It keeps an enable flag, a pending flag and a 3-bit priority for each line, and it offers the processor one request: a flag plus the number of the winning line. Software reaches the state through a simple word-addressed register bus with a write strobe and combinational read data. Enable and pending state each have a set word and a clear word. Writing a one to a bit acts on that line. Writing a zero to a bit leaves that line alone.

A line competes for the output only when it is pending and enabled, and the threshold mask must not block it. The lowest priority value wins. When several lines share that value, the lowest line number wins. The threshold compares only the preemption part of each priority. A grouping register, protected by a write key, sets how many upper bits form that part. The processor accepts a request by raising `ack_i` while `req_o` is high. This clears the pending flag of the line shown on `id_o`. The pair behaves like valid/ready with no back-pressure on the controller. `req_o` and `id_o` can change before an acknowledge when the eligible set changes, so the processor must sample both in the cycle it acknowledges.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all lines are disabled, nothing is pending, every priority is 0, the threshold is 0, the grouping value is 3, and `req_o` is low.
- R2: Line n lives in bank n/32 at bit n%32. A write to word 0x00+bank sets the enable of each line whose data bit is 1. A write to word 0x04+bank clears it. Zero bits change nothing. Both words read back the enable bits.
- R3: Word 0x08+bank sets pending bits and word 0x0C+bank clears them, with the same bit layout. Both words read back the pending bits. A set from the hardware line or the bus wins over a clear in the same cycle.
- R4: A high level on `irq_i[n]` at a clock edge sets pending bit n. The bit stays set after the line drops, until it is cleared.
- R5: A pending line that is not enabled never drives `req_o` or `id_o`.
- R6: The priority of line n sits in word 0x10+n/4, byte n%4 (bits 8*(n%4)+7 down to 8*(n%4)). Only the top 3 bits of the byte are stored. The low 5 bits read as zero and play no part in arbitration.
- R7: Among eligible lines the smallest priority value wins. On a tie the lowest line number wins.
- R8: The threshold is word 0x31, bits 7:5. When it is nonzero, it blocks every line whose preemption part is greater than or equal to it. A value of 0 blocks nothing.
- R9: The grouping value is word 0x30, bits 2:0. It gives the number of upper priority bits that form the preemption part. Values 3 to 7 all mean all 3 bits, and bits below the preemption part are ignored by the threshold.
- R10: A grouping write takes effect only when bits 31:16 of the data equal 0xC1A5. Any other write to word 0x30 is ignored.
- R11: `req_o` and `id_o` are registered. They show the arbitration result of the state held just before the clock edge that loads them.
- R12: `ack_i` high at a clock edge while `req_o` is high clears the pending bit of line `id_o`, unless a set arrives in the same cycle. `ack_i` has no effect while `req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_i | input | NUM_IRQ | Level-sensitive interrupt lines |
| ack_i | input | 1 | Processor accepts the shown request |
| req_o | output | 1 | A request is presented |
| id_o | output | clog2(NUM_IRQ) | Number of the winning line |

## Verification
The bench goes after a disabled line that holds the best priority. A controller that skips the enable gate would pick that line. It also checks a tie on priority, where a reversed scan would return the higher line number. It checks that an acknowledge cannot clear a line whose level input is still high, and that a bus clear cannot win over a hardware set in the same cycle; a wrong ordering would drop a live interrupt. The threshold is tried under several grouping values and after a write with a bad key. A design that compared the full priority, or that accepted an unkeyed write, would block or pass the wrong lines. A behavioural model compares `req_o` and `id_o` on every clock, so an extra or a missing output register shows up as a one-cycle shift.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] EN_SET_BASE = 6'h00;
  localparam logic [ADDR_W-1:0] EN_CLR_BASE = 6'h04;
  localparam logic [ADDR_W-1:0] PD_SET_BASE = 6'h08;
  localparam logic [ADDR_W-1:0] PD_CLR_BASE = 6'h0C;
  localparam logic [ADDR_W-1:0] PRIO_BASE   = 6'h10;
  localparam logic [ADDR_W-1:0] GROUP_ADDR  = 6'h30;
  localparam logic [ADDR_W-1:0] MASK_ADDR   = 6'h31;
  localparam logic [15:0]       GROUP_KEY   = 16'hC1A5;
  localparam logic [2:0]        GROUP_RESET = 3'd3;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [31:0]                     wdata_i,
  input  logic                            we_i,
  output logic [31:0]                     rdata_o,
  input  logic [NUM_IRQ-1:0]              irq_i,
  input  logic [NUM_IRQ-1:0]              ack_clr_i,
  output logic [NUM_IRQ-1:0]              en_o,
  output logic [NUM_IRQ-1:0]              pend_o,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_o,
  output logic [PRIO_W-1:0]               mask_o,
  output logic [2:0]                      group_o
);
  localparam int NBANK = (NUM_IRQ + 31) / 32;
  localparam int PAD   = NBANK * 32;
  localparam int LO_W  = 8 - PRIO_W;

  // per-line storage and write decode
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    localparam int BANK = n / 32;
    localparam int BITP = n % 32;
    localparam int WORD = n / 4;
    localparam int LANE = n % 4;
    logic hit_es, hit_ec, hit_ps, hit_pc, hit_pr;
    logic en_r, pend_r;
    logic [PRIO_W-1:0] prio_r;

    always_comb begin
      hit_es = we_i && (addr_i == EN_SET_BASE + ADDR_W'(BANK)) && wdata_i[BITP];
      hit_ec = we_i && (addr_i == EN_CLR_BASE + ADDR_W'(BANK)) && wdata_i[BITP];
      hit_ps = we_i && (addr_i == PD_SET_BASE + ADDR_W'(BANK)) && wdata_i[BITP];
      hit_pc = we_i && (addr_i == PD_CLR_BASE + ADDR_W'(BANK)) && wdata_i[BITP];
      hit_pr = we_i && (addr_i == PRIO_BASE + ADDR_W'(WORD));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_r   <= 1'b0;
        pend_r <= 1'b0;
        prio_r <= '0;
      end else begin
        if (hit_es)      en_r <= 1'b1;
        else if (hit_ec) en_r <= 1'b0;
        if (hit_ps || irq_i[n])           pend_r <= 1'b1;
        else if (hit_pc || ack_clr_i[n])  pend_r <= 1'b0;
        if (hit_pr) prio_r <= wdata_i[8*LANE+7 -: PRIO_W];
      end
    end

    assign en_o[n]   = en_r;
    assign pend_o[n] = pend_r;
    assign prio_o[n] = prio_r;
  end

  // keyed grouping and threshold registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o <= GROUP_RESET;
      mask_o  <= '0;
    end else if (we_i) begin
      if (addr_i == GROUP_ADDR && wdata_i[31:16] == GROUP_KEY) group_o <= wdata_i[2:0];
      if (addr_i == MASK_ADDR) mask_o <= wdata_i[7 -: PRIO_W];
    end
  end

  // read mux
  logic [PAD-1:0] en_pad, pd_pad;
  int bank;
  always_comb begin
    en_pad = '0;
    pd_pad = '0;
    en_pad[NUM_IRQ-1:0] = en_o;
    pd_pad[NUM_IRQ-1:0] = pend_o;
    bank    = int'(addr_i[1:0]);
    rdata_o = '0;
    if (addr_i[5:3] == 3'b000) begin
      if (bank < NBANK) rdata_o = en_pad[32*bank +: 32];
    end else if (addr_i[5:3] == 3'b001) begin
      if (bank < NBANK) rdata_o = pd_pad[32*bank +: 32];
    end else if (addr_i == GROUP_ADDR) begin
      rdata_o[2:0] = group_o;
    end else if (addr_i == MASK_ADDR) begin
      rdata_o[7:0] = {mask_o, LO_W'(0)};
    end else begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        if (addr_i == PRIO_BASE + ADDR_W'(n / 4))
          rdata_o[8*(n%4) +: 8] = {prio_o[n], LO_W'(0)};
      end
    end
  end
endmodule

// File: rtl/irq_filter.sv
module irq_filter #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_IRQ-1:0]             en_i,
  input  logic [NUM_IRQ-1:0]             pend_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              mask_i,
  input  logic [2:0]                     group_i,
  output logic [NUM_IRQ-1:0]             elig_o
);
  logic [PRIO_W-1:0] pre_mask;
  int pre_bits;

  // preemption part: upper min(group, PRIO_W) bits
  always_comb begin
    pre_bits = (int'(group_i) > PRIO_W) ? PRIO_W : int'(group_i);
    pre_mask = ~({PRIO_W{1'b1}} >> pre_bits);
  end

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_elig
    assign elig_o[n] = en_i[n] && pend_i[n] &&
                       ((mask_i == '0) || ((prio_i[n] & pre_mask) < mask_i));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_IRQ-1:0]             elig_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  output logic                           any_o,
  output logic [ID_W-1:0]                id_o
);
  logic              found;
  logic [PRIO_W-1:0] best;
  logic [ID_W-1:0]   win;

  // ascending scan with strict compare keeps the lowest number on ties
  always_comb begin
    found = 1'b0;
    best  = '1;
    win   = '0;
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (elig_i[n] && (!found || prio_i[n] < best)) begin
        found = 1'b1;
        best  = prio_i[n];
        win   = ID_W'(n);
      end
    end
    any_o = found;
    id_o  = win;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter  int NUM_IRQ = 32,
  parameter  int PRIO_W  = 3,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  input  logic                bus_we_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_IRQ-1:0]  irq_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic [ID_W-1:0]     id_o
);
  logic [NUM_IRQ-1:0]             en_w, pend_w, elig_w, ack_clr;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_w;
  logic [PRIO_W-1:0]              mask_w;
  logic [2:0]                     group_w;
  logic                           any_w;
  logic [ID_W-1:0]                win_w;

  always_comb begin
    ack_clr = '0;
    if (ack_i && req_o) ack_clr[id_o] = 1'b1;
  end

  irq_regfile #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .we_i(bus_we_i), .rdata_o(bus_rdata_o), .irq_i(irq_i), .ack_clr_i(ack_clr),
    .en_o(en_w), .pend_o(pend_w), .prio_o(prio_w), .mask_o(mask_w), .group_o(group_w)
  );

  irq_filter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_filter (
    .en_i(en_w), .pend_i(pend_w), .prio_i(prio_w), .mask_i(mask_w),
    .group_i(group_w), .elig_o(elig_w)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .elig_i(elig_w), .prio_i(prio_w), .any_o(any_w), .id_o(win_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      id_o  <= '0;
    end else begin
      req_o <= any_w;
      id_o  <= win_w;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int ID_W    = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic               bus_we_i,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               ack_i,
  input logic               req_o,
  input logic [ID_W-1:0]    id_o,
  input logic [NUM_IRQ-1:0] en_i,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] elig_i,
  input logic [2:0]         group_i
);
  logic [NUM_IRQ-1:0] elig_d;
  logic [ID_W-1:0]    id_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elig_d <= '0;
      id_d   <= '0;
    end else begin
      elig_d <= elig_i;
      id_d   <= id_o;
    end
  end

  AST_WIN_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> elig_d[id_o]); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|elig_d) |-> !req_o); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && req_o && !irq_i[id_o] && !bus_we_i |=> !pend_i[id_d]); // R12
  AST_EN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(en_i)); // R2
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == GROUP_ADDR && bus_wdata_i[31:16] != GROUP_KEY
    |=> $stable(group_i)); // R10
  AST_LEVEL_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |=> ((pend_i & $past(irq_i)) == $past(irq_i))); // R4
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .bus_we_i(bus_we_i), .irq_i(irq_i), .ack_i(ack_i), .req_o(req_o), .id_o(id_o),
  .en_i(en_w), .pend_i(pend_w), .elig_i(elig_w), .group_i(group_w)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [4:0]  id;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .PRIO_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_we_i(bus_we), .bus_rdata_o(bus_rdata), .irq_i(irq), .ack_i(ack),
    .req_o(req), .id_o(id)
  );

  // behavioural reference model
  bit [31:0] m_en, m_pd;
  int        m_pr[N];
  int        m_mask, m_group;
  bit        exp_req;
  int        exp_id;

  function automatic void model_arb(output bit r, output int w);
    int pre, best;
    r = 0; w = 0; best = 99;
    pre = (m_group > 3) ? 3 : m_group;
    for (int n = 0; n < N; n++) begin
      int eff;
      bit ok;
      eff = (m_pr[n] >> (3 - pre)) << (3 - pre);
      ok  = m_en[n] && m_pd[n] && (m_mask == 0 || eff < m_mask);
      if (ok && m_pr[n] < best) begin best = m_pr[n]; w = n; r = 1; end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pd = 0; m_mask = 0; m_group = 3;
      exp_req = 0; exp_id = 0;
      for (int n = 0; n < N; n++) m_pr[n] = 0;
    end else begin
      bit nr;
      int nw;
      bit [31:0] pset, pclr;
      model_arb(nr, nw);
      pset = 0; pclr = 0;
      if (ack && exp_req) pclr[exp_id] = 1'b1;
      if (bus_we) begin
        if (bus_addr == 6'h00) m_en = m_en | bus_wdata;
        if (bus_addr == 6'h04) m_en = m_en & ~bus_wdata;
        if (bus_addr == 6'h08) pset = bus_wdata;
        if (bus_addr == 6'h0C) pclr = pclr | bus_wdata;
        if (bus_addr >= 6'h10 && bus_addr < 6'h18)
          for (int l = 0; l < 4; l++)
            m_pr[(int'(bus_addr) - 16) * 4 + l] = int'((bus_wdata >> (8*l + 5)) & 32'd7);
        if (bus_addr == 6'h30 && bus_wdata[31:16] == 16'hC1A5) m_group = int'(bus_wdata[2:0]);
        if (bus_addr == 6'h31) m_mask = int'(bus_wdata[7:5]);
      end
      m_pd = (m_pd & ~pclr) | pset | irq;
      exp_req = nr;
      exp_id  = nw;
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R7 R11)
  always @(negedge clk) begin
    if (rst_n)
      check(req == exp_req && (!exp_req || int'(id) == exp_id), "R7 R11 per-cycle output",
            {req, id}, {exp_req, 5'(exp_id)});
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic out_chk(input bit r, input int w, input string tag);
    check(req == r && (!r || int'(id) == w), tag, {req, id}, {r, 5'(w)});
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    out_chk(0, 0, "R1 req low after reset");
    rd_chk(6'h00, 32'h0, "R1 enable reset");
    rd_chk(6'h08, 32'h0, "R1 pending reset");
    rd_chk(6'h10, 32'h0, "R1 priority reset");
    rd_chk(6'h30, 32'h3, "R1 grouping reset");
    rd_chk(6'h31, 32'h0, "R1 threshold reset");
    // R2 enable set/clear, zero bits inert
    wr(6'h00, 32'hF0);
    wr(6'h00, 32'h0);
    rd_chk(6'h00, 32'hF0, "R2 enable set");
    rd_chk(6'h04, 32'hF0, "R2 enable via clear word");
    wr(6'h04, 32'h10);
    rd_chk(6'h00, 32'hE0, "R2 enable clear");
    wr(6'h04, 32'h0);
    rd_chk(6'h00, 32'hE0, "R2 zero clear inert");
    // R6 priority packing, low bits dropped
    wr(6'h11, 32'h6040FF20);
    rd_chk(6'h11, 32'h6040E020, "R6 priority readback");
    // R3 / R11 / R5 / R7
    wr(6'h08, 32'hF0);
    out_chk(0, 0, "R11 output one cycle late");
    rd_chk(6'h08, 32'hF0, "R3 pending set");
    idle(1);
    out_chk(1, 6, "R5 R7 disabled line 4 skipped");
    wr(6'h11, 32'h6060FF20);
    idle(1);
    out_chk(1, 6, "R7 tie lowest number");
    // R12 acknowledge
    ack_pulse();
    idle(1);
    out_chk(1, 7, "R12 ack clears winner");
    rd_chk(6'h0C, 32'hB0, "R12 R3 pending after ack");
    // R8 threshold
    wr(6'h31, 32'h60);
    idle(1);
    out_chk(0, 0, "R8 threshold blocks");
    rd_chk(6'h31, 32'h60, "R8 threshold readback");
    wr(6'h31, 32'h80);
    idle(1);
    out_chk(1, 7, "R8 higher threshold passes");
    wr(6'h31, 32'h60);
    // R10 keyed grouping
    wr(6'h30, 32'h00000001);
    rd_chk(6'h30, 32'h3, "R10 bad key ignored");
    idle(1);
    out_chk(0, 0, "R10 bad key no effect on masking");
    // R9 grouping
    wr(6'h30, 32'hC1A50001);
    rd_chk(6'h30, 32'h1, "R9 grouping written");
    idle(1);
    out_chk(1, 7, "R9 subpriority ignored by threshold");
    wr(6'h30, 32'hC1A50005);
    idle(1);
    out_chk(0, 0, "R9 grouping 5 acts as 3");
    wr(6'h31, 32'h0);
    idle(1);
    out_chk(1, 7, "R8 zero threshold");
    // R4 level input
    wr(6'h00, 32'h00100000);
    @(negedge clk); irq[20] = 1'b1;
    @(negedge clk); irq[20] = 1'b0;
    idle(1);
    out_chk(1, 20, "R4 pulse latched");
    rd_chk(6'h08, 32'h001000B0, "R4 pending bit held");
    // R12 ack with line still high
    irq[20] = 1'b1;
    ack_pulse();
    idle(1);
    out_chk(1, 20, "R12 live line stays pending");
    irq[20] = 1'b0;
    ack_pulse();
    idle(1);
    out_chk(1, 7, "R12 ack after line drop");
    // R3 set wins over clear
    @(negedge clk);
    irq[20] = 1'b1; bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h00100000;
    @(negedge clk);
    irq[20] = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    rd_chk(6'h08, 32'h001000B0, "R3 set wins over clear");
    wr(6'h0C, 32'h00100000);
    rd_chk(6'h08, 32'hB0, "R3 pending clear");
    wr(6'h0C, 32'h0);
    rd_chk(6'h08, 32'hB0, "R3 zero clear inert");
    // R5 pending but disabled, priority 0
    wr(6'h08, 32'h02000000);
    idle(1);
    out_chk(1, 7, "R5 disabled line 25 ignored");
    wr(6'h04, 32'h80);
    idle(1);
    out_chk(1, 5, "R2 R7 disable winner");
    // R12 ack ignored when req low
    wr(6'h04, 32'hFFFFFFFF);
    idle(1);
    out_chk(0, 0, "R2 all disabled");
    ack_pulse();
    rd_chk(6'h08, 32'h020000B0, "R12 ack ignored without req");
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule